// File: doc/BRIEF.md
# Serial EEPROM Station Address Fetcher

This block is a bus master for a three-wire serial EEPROM. It drives the chip-select, serial clock and serial data lines towards the memory and listens on the memory's data return line. One start pulse makes it fetch three 16-bit words, from word addresses 0, 1 and 2. It then packs those six bytes into a 48-bit station (MAC) address and pulses a done flag.

Each word takes its own chip-select window. Inside it the block shifts out a leading zero, the 3-bit read opcode and an 8-bit word address. It then clocks in seventeen bits: it throws away the first and keeps the next sixteen. The serial clock's half-period is a whole number of system clock cycles, set by a parameter. A host controller would issue start once after power-up and latch the address when done is seen.

Top module: `serial_rom_macaddr`

## Requirements
- R1: After a synchronous active-high reset, rom_sel, rom_clk, rom_mosi, busy and done are 0 and mac_addr is 0. Whenever busy is 0, the three memory lines stay low.
- R2: A start pulse while idle produces exactly three chip-select windows, addressing words 0, 1 and 2 in that order.
- R3: Each window first sends 12 bits on rom_mosi, sampled by the memory at rising rom_clk edges: a 0, then the read opcode 1,1,0, then the 8-bit word address, most significant bit first.
- R4: Every serial bit is a low phase of rom_clk followed by a high phase. Each phase lasts HALF_CYC system clocks. rom_mosi is set before the low phase and does not change at the rising edge.
- R5: rom_sel rises while rom_clk and rom_mosi are low. rom_clk is held low for one extra half-period before the first bit, so 2*HALF_CYC clocks pass from rom_sel rising to the first rising rom_clk. rom_clk never goes high while rom_sel is low.
- R6: After the address, 17 further clock periods follow, with rom_mosi held low. rom_miso is sampled late in each low phase. The first sample is discarded and the next 16 form the word, most significant bit first. Each window therefore has 29 rising rom_clk edges.
- R7: Byte order: mac_addr[47:40] = word0[7:0], [39:32] = word0[15:8], [31:24] = word1[7:0], [23:16] = word1[15:8], [15:8] = word2[7:0], [7:0] = word2[15:8].
- R8: After each window, rom_sel, rom_clk and rom_mosi all go low together. done is a single-cycle pulse, issued once per fetch, in the same cycle that busy falls.
- R9: A start pulse while busy is ignored: there is no extra window and no extra done, and the result is unchanged.
- R10: busy rises on the clock edge that captures start and stays high until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to fetch the address |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse when mac_addr is complete |
| mac_addr | output | 48 | Assembled station address, first byte in bits 47:40 |
| rom_sel | output | 1 | EEPROM chip select, active high |
| rom_clk | output | 1 | EEPROM serial clock |
| rom_mosi | output | 1 | Serial data towards the EEPROM |
| rom_miso | input | 1 | Serial data from the EEPROM |

## Verification
The embedded properties check on every cycle that the lines are quiet while idle and that the clock is gated by the select. They also check that outgoing data is stable across each rising clock edge and held low during reception. They check that done is a lone pulse ending busy, and that busy only rises after a start. Frame content, window count, phase lengths, the discarded sample and the byte order are visible only to the bench's EEPROM model. That model decodes every window against several stored word sets and measures the clock phases in system cycles. Starts issued mid-fetch and a reset issued mid-window are also directed scenarios.

// File: rtl/serial_rom_macaddr.sv
module serial_rom_macaddr #(
  parameter int HALF_CYC = 4,
  parameter int ADDR_W   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic [47:0] mac_addr,
  output logic        rom_sel,
  output logic        rom_clk,
  output logic        rom_mosi,
  input  logic        rom_miso
);
  localparam int CW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int FRAME_W = 4 + ADDR_W;
  localparam int RX_BITS = 17;
  localparam int BW      = $clog2(FRAME_W + RX_BITS);
  localparam int NWORDS  = 3;
  localparam logic [2:0] OP_RD = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SEND, S_RECV, S_GAP} st_t;

  st_t                state;
  logic [CW-1:0]      cnt;
  logic               tick;
  logic               phase;
  logic [BW-1:0]      bitn;
  logic [1:0]         word;
  logic [FRAME_W-1:0] tx_sh;
  logic [15:0]        rx_sh;
  logic [FRAME_W-1:0] frame;

  assign tick  = (cnt == CW'(HALF_CYC - 1));
  assign frame = {1'b0, OP_RD, ADDR_W'(word)};

  always_ff @(posedge clk) begin
    if (rst || state == S_IDLE || tick) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      mac_addr <= '0;
      rom_sel  <= 1'b0;
      rom_clk  <= 1'b0;
      rom_mosi <= 1'b0;
      phase    <= 1'b0;
      bitn     <= '0;
      word     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_SETUP;
          busy     <= 1'b1;
          word     <= '0;
          rom_sel  <= 1'b1;
          rom_clk  <= 1'b0;
          rom_mosi <= 1'b0;
        end
        S_SETUP: if (tick) begin
          state    <= S_SEND;
          phase    <= 1'b0;
          bitn     <= BW'(FRAME_W - 1);
          rom_mosi <= frame[FRAME_W-1];
          tx_sh    <= frame << 1;
        end
        S_SEND: if (tick) begin
          if (!phase) begin
            rom_clk <= 1'b1;
            phase   <= 1'b1;
          end else begin
            rom_clk <= 1'b0;
            phase   <= 1'b0;
            if (bitn == '0) begin
              state    <= S_RECV;
              bitn     <= BW'(RX_BITS - 1);
              rom_mosi <= 1'b0;
            end else begin
              bitn     <= bitn - 1'b1;
              rom_mosi <= tx_sh[FRAME_W-1];
              tx_sh    <= tx_sh << 1;
            end
          end
        end
        S_RECV: if (tick) begin
          if (!phase) begin
            rx_sh   <= {rx_sh[14:0], rom_miso};
            rom_clk <= 1'b1;
            phase   <= 1'b1;
          end else begin
            rom_clk <= 1'b0;
            phase   <= 1'b0;
            if (bitn == '0) begin
              state   <= S_GAP;
              rom_sel <= 1'b0;
              mac_addr[(47 - 16*int'(word)) -: 8] <= rx_sh[7:0];
              mac_addr[(39 - 16*int'(word)) -: 8] <= rx_sh[15:8];
            end else begin
              bitn <= bitn - 1'b1;
            end
          end
        end
        S_GAP: if (tick) begin
          if (word == 2'(NWORDS - 1)) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            state   <= S_SETUP;
            word    <= word + 1'b1;
            rom_sel <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rom_sel && !rom_clk && !rom_mosi));
  a_r5_clk_gated: assert property (@(posedge clk) disable iff (rst)
    !rom_sel |-> !rom_clk);
  a_r4_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_clk) |-> $stable(rom_mosi));
  a_r6_mosi_low_rx: assert property (@(posedge clk) disable iff (rst)
    (state == S_RECV) |-> !rom_mosi);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/serial_rom_macaddr_bench.sv
module serial_rom_macaddr_bench;
  localparam int H = 4;
  localparam int NV = 4;
  localparam logic [47:0] VEC [NV] = '{
    48'h1234_5678_9ABC, 48'h0000_0000_0000,
    48'hFFFF_FFFF_FFFF, 48'hA55A_0180_FF00 };

  logic clk = 0, rst = 1, start = 0, rom_miso = 0;
  logic busy, done, rom_sel, rom_clk, rom_mosi;
  logic [47:0] mac_addr;
  int errors = 0, checks = 0, wd = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  serial_rom_macaddr #(.HALF_CYC(H)) u_serial_rom_macaddr (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mac_addr(mac_addr), .rom_sel(rom_sel), .rom_clk(rom_clk),
    .rom_mosi(rom_mosi), .rom_miso(rom_miso));

  logic [15:0] words [3];
  int frames, done_cnt, nedge, cyc, t_sel, t_rise, t_fall;
  int r3_bad, r4_bad, r5_bad, r6_bad, r8_bad;
  logic [11:0] cmd;
  logic psel = 0, pclk = 0;

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (rom_sel && !psel) begin
      t_sel = cyc; nedge = 0; cmd = '0;
      if (rom_clk || rom_mosi) r5_bad++;
    end
    if (rom_sel && rom_clk && !pclk) begin
      nedge++;
      if (nedge == 1) begin if (cyc - t_sel != 2*H) r5_bad++; end
      else if (cyc - t_fall != H) r4_bad++;
      t_rise = cyc;
      if (nedge <= 12) cmd = {cmd[10:0], rom_mosi};
      else if (rom_mosi) r6_bad++;
      if (nedge == 12) rom_miso <= 1'b1;
      else if (nedge >= 13 && nedge <= 28 && frames < 3) rom_miso <= words[frames][28-nedge];
      else rom_miso <= 1'b0;
    end
    if (rom_sel && !rom_clk && pclk) begin
      if (cyc - t_rise != H) r4_bad++;
      t_fall = cyc;
    end
    if (!rom_sel && psel) begin
      if (nedge != 29 || rom_clk || rom_mosi) r8_bad++;
      if (cmd != {1'b0, 3'b110, 8'(frames)}) r3_bad++;
      frames++;
    end
    psel = rom_sel; pclk = rom_clk;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", wd);
      summary();
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_start();
    start = 1; tick_n(1); start = 0;
  endtask

  task automatic run(logic [47:0] v, bit extra);
    logic [47:0] exp;
    int t;
    tick_n(1);
    words[0] = v[47:32]; words[1] = v[31:16]; words[2] = v[15:0];
    frames = 0; done_cnt = 0; r3_bad = 0; r4_bad = 0; r5_bad = 0; r6_bad = 0; r8_bad = 0;
    exp = {v[39:32], v[47:40], v[23:16], v[31:24], v[7:0], v[15:8]};
    start = 1; tick_n(1); start = 0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    if (extra) begin tick_n(300); pulse_start(); end
    t = 0;
    while (!done && t < 5000) begin tick_n(1); t++; end
    check(busy == 1'b0, "R8 busy low at done", busy, 0);
    tick_n(H * 4);
    check(frames == 3, extra ? "R9 windows with extra start" : "R2 window count", frames, 3);
    check(done_cnt == 1, extra ? "R9 done count" : "R8 done count", done_cnt, 1);
    check(mac_addr == exp, "R7 mac byte order / R6 capture", mac_addr, exp);
    check(r3_bad == 0, "R3 frame bits", r3_bad, 0);
    check(r4_bad == 0, "R4 phase timing", r4_bad, 0);
    check(r5_bad == 0, "R5 select setup", r5_bad, 0);
    check(r6_bad == 0, "R6 mosi low in rx", r6_bad, 0);
    check(r8_bad == 0, "R8 window end", r8_bad, 0);
    check({rom_sel, rom_clk, rom_mosi} == 3'b000, "R1 idle lines", {rom_sel, rom_clk, rom_mosi}, 0);
  endtask

  initial begin
    tick_n(3);
    rst = 0; tick_n(1);
    check({rom_sel, rom_clk, rom_mosi, busy, done} == 5'b0, "R1 reset outputs",
          {rom_sel, rom_clk, rom_mosi, busy, done}, 0);
    check(mac_addr == 48'h0, "R1 reset mac", mac_addr, 0);
    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);
    run(48'hDEAD_BEEF_0F1E, 1'b1);
    tick_n(1);
    pulse_start();
    tick_n(100);
    check(rom_sel == 1'b1, "R2 window open mid-run", rom_sel, 1);
    rst = 1; tick_n(1); rst = 0;
    check({rom_sel, rom_clk, rom_mosi, busy} == 4'b0, "R1 reset mid-run",
          {rom_sel, rom_clk, rom_mosi, busy}, 0);
    check(mac_addr == 48'h0, "R1 mac cleared by reset", mac_addr, 0);
    tick_n(50);
    check({rom_sel, rom_clk, busy, done_cnt != 1} == 4'b0, "R1 stays idle after reset",
          {rom_sel, rom_clk, busy}, 0);
    run(48'h0102_0304_0506, 1'b0);
    summary();
  end
endmodule